// File: doc/BRIEF.md
# Nested Fixed-Priority Interrupt Controller

This block sits between a bank of interrupt request lines and a processor. A rising edge on a request line marks that channel as pending. The controller presents at most one pending channel to the processor at a time, using a valid/acknowledge handshake and a channel number. Priority is fixed by channel index, and the highest index wins. Nothing about priority can be programmed.

Once the processor acknowledges a channel, the controller marks that channel's level as in service. From then on, only a pending channel that strictly outranks every in-service level can reach the processor. This lets a more urgent handler pre-empt a running one, and handlers can nest as deep as there are channels. When a handler finishes, the processor pulses a return strobe. The strobe retires the innermost (highest) in-service level, so the enclosing handler's level applies again. Any request that was held back becomes eligible once the level drops below it.

Saving the processor's context, vector storage and the handlers themselves are outside this block.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset, irq_valid is 0, no channel is pending and no level is in service.
- R2: A 0-to-1 transition on irq_req[i] makes channel i pending. A request held high after its acknowledge does not make the channel pending again.
- R3: Among eligible pending channels, the one with the highest index is presented on irq_id. Channel N_CH-1 is the most urgent and channel 0 the least.
- R4: While no level is in service, every pending channel is eligible, and irq_valid is high whenever any channel is pending.
- R5: A pending channel whose index is equal to or below the highest in-service index is held back and is not presented.
- R6: A pending channel whose index is above the highest in-service index is presented while that handler is still in service (pre-emption).
- R7: A cycle with irq_valid and irq_ack both high clears the pending bit of the presented channel and puts that channel in service. irq_ack while irq_valid is low has no effect.
- R8: An irq_ret pulse takes the highest in-service channel out of service, which restores the previous level.
- R9: irq_ret while no channel is in service has no effect.
- R10: When irq_ret and an accepted irq_ack fall in the same cycle, the return is applied first and the acknowledged channel is then put in service.
- R11: While irq_valid is high and no acknowledge arrives, irq_valid stays high and irq_id never decreases. It changes only when a more urgent channel becomes eligible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | N_CH | Request lines, one per channel, edge sensitive |
| irq_valid | output | 1 | A channel is being presented to the processor |
| irq_id | output | ID_W | Index of the presented channel |
| irq_ack | input | 1 | Processor accepts the presented channel |
| irq_ret | input | 1 | Processor finished its innermost handler |

## Verification
The bench builds the controller with the default eight channels. This is enough to nest several handlers, to hold back both equal and lower requests, and to move the presented channel upward before an acknowledge arrives. With eight channels, a combined return and acknowledge can also be arranged so that the two possible orderings leave different channels eligible, which makes the ordering visible at irq_valid and irq_id. A behavioural reference model is compared with the outputs on every clock, alongside directed checks of the nesting corners.

// File: rtl/nest_irq_pkg.sv
package nest_irq_pkg;

  // Index of the highest set bit, or -1 when the vector is empty.
  function automatic int top_index(input logic [31:0] v);
    int r;
    r = -1;
    for (int i = 0; i < 32; i++) begin
      if (v[i]) r = i;
    end
    return r;
  endfunction

  // Bits strictly above lvl set; lvl < 0 gives all ones.
  function automatic logic [31:0] above_mask(input int lvl);
    logic [31:0] m;
    if (lvl < 0) m = '1;
    else if (lvl >= 31) m = '0;
    else m = ~((32'd2 << lvl) - 32'd1);
    return m;
  endfunction

endpackage

// File: rtl/nest_irq_pend.sv
module nest_irq_pend #(
  parameter int N_CH = 8,
  localparam int ID_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_CH-1:0] req,
  input  logic            clr_vld,
  input  logic [ID_W-1:0] clr_idx,
  output logic [N_CH-1:0] pend,
  output logic [N_CH-1:0] rise
);

  logic [N_CH-1:0] req_q;

  always_ff @(posedge clk) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= req;
  end

  assign rise = req & ~req_q;

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    logic hit;
    assign hit = clr_vld && (clr_idx == ID_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n)       pend[g] <= 1'b0;
      else if (rise[g]) pend[g] <= 1'b1;
      else if (hit)     pend[g] <= 1'b0;
    end
  end

endmodule

// File: rtl/nest_irq_stack.sv
module nest_irq_stack #(
  parameter int N_CH = 8,
  localparam int ID_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ret,
  input  logic            push_vld,
  input  logic [ID_W-1:0] push_idx,
  output logic [N_CH-1:0] isv,
  output logic            pop_vld
);
  import nest_irq_pkg::*;

  logic [ID_W-1:0] pop_idx;
  logic [N_CH-1:0] isv_n;

  assign pop_vld = ret && (isv != '0);
  assign pop_idx = ID_W'(top_index(32'(isv)));

  always_comb begin
    isv_n = isv;
    if (pop_vld)  isv_n[pop_idx]  = 1'b0;
    if (push_vld) isv_n[push_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) isv <= '0;
    else        isv <= isv_n;
  end

endmodule

// File: rtl/nest_irq_select.sv
module nest_irq_select #(
  parameter int N_CH = 8,
  localparam int ID_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic [N_CH-1:0] pend,
  input  logic [N_CH-1:0] isv,
  output logic [N_CH-1:0] eligible,
  output logic            valid,
  output logic [ID_W-1:0] id
);
  import nest_irq_pkg::*;

  assign eligible = pend & N_CH'(above_mask(top_index(32'(isv))));
  assign valid    = |eligible;
  assign id       = valid ? ID_W'(top_index(32'(eligible))) : '0;

endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl #(
  parameter int N_CH = 8,
  localparam int ID_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_CH-1:0] irq_req,
  output logic            irq_valid,
  output logic [ID_W-1:0] irq_id,
  input  logic            irq_ack,
  input  logic            irq_ret
);

  logic [N_CH-1:0] pend_w;
  logic [N_CH-1:0] rise_w;
  logic [N_CH-1:0] isv_w;
  logic [N_CH-1:0] elig_w;
  logic            ack_take;
  logic            ret_pop;

  assign ack_take = irq_valid && irq_ack;

  nest_irq_pend #(.N_CH(N_CH)) u_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (irq_req),
    .clr_vld (ack_take),
    .clr_idx (irq_id),
    .pend    (pend_w),
    .rise    (rise_w)
  );

  nest_irq_stack #(.N_CH(N_CH)) u_stack (
    .clk      (clk),
    .rst_n    (rst_n),
    .ret      (irq_ret),
    .push_vld (ack_take),
    .push_idx (irq_id),
    .isv      (isv_w),
    .pop_vld  (ret_pop)
  );

  nest_irq_select #(.N_CH(N_CH)) u_sel (
    .pend     (pend_w),
    .isv      (isv_w),
    .eligible (elig_w),
    .valid    (irq_valid),
    .id       (irq_id)
  );

endmodule

// File: rtl/nest_irq_ctrl_chk.sv
module nest_irq_ctrl_chk #(
  parameter int N_CH = 8,
  localparam int ID_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic [N_CH-1:0] irq_req,
  input logic            irq_valid,
  input logic [ID_W-1:0] irq_id,
  input logic            irq_ack,
  input logic            irq_ret,
  input logic [N_CH-1:0] pend_w,
  input logic [N_CH-1:0] isv_w,
  input logic [N_CH-1:0] rise_w,
  input logic            ack_take,
  input logic            ret_pop
);

  AST_PRESENTED_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> pend_w[irq_id]); // R3

  AST_ABOVE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> ((isv_w >> irq_id) == '0)); // R5

  AST_ID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !irq_ack) |=> (irq_valid && irq_id >= $past(irq_id))); // R11

  AST_ACK_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_take && !irq_req[irq_id]) |=> (isv_w[$past(irq_id)] && !pend_w[$past(irq_id)])); // R7

  AST_RET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ret && isv_w == '0 && !irq_ack) |=> (isv_w == '0)); // R9

  AST_RET_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_pop && !ack_take) |=> ($countones(isv_w) + 1 == $countones($past(isv_w)))); // R8

  AST_EDGE_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_w != '0) |=> ((pend_w & $past(rise_w)) == $past(rise_w))); // R2

endmodule

bind nest_irq_ctrl nest_irq_ctrl_chk #(.N_CH(N_CH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_req   (irq_req),
  .irq_valid (irq_valid),
  .irq_id    (irq_id),
  .irq_ack   (irq_ack),
  .irq_ret   (irq_ret),
  .pend_w    (pend_w),
  .isv_w     (isv_w),
  .rise_w    (rise_w),
  .ack_take  (ack_take),
  .ret_pop   (ret_pop)
);

// File: tb/nest_irq_ctrl_tb.sv
module nest_irq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] irq_req = '0;
  logic         irq_ack = 1'b0;
  logic         irq_ret = 1'b0;
  logic         irq_valid;
  logic [2:0]   irq_id;

  int checks = 0;
  int errors = 0;
  string cur_tag = "R1";

  // Reference model state
  bit [N-1:0] m_prev, m_pend, m_isv;

  always #(CLK_PERIOD/2) clk = ~clk;

  nest_irq_ctrl #(.N_CH(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req),
    .irq_valid(irq_valid), .irq_id(irq_id),
    .irq_ack(irq_ack), .irq_ret(irq_ret)
  );

  function automatic int m_level(bit [N-1:0] s);
    int l = -1;
    for (int i = 0; i < N; i++) if (s[i]) l = i;
    return l;
  endfunction

  function automatic int m_pick(bit [N-1:0] p, bit [N-1:0] s);
    int best = -1;
    int lvl = m_level(s);
    for (int i = lvl + 1; i < N; i++) if (p[i]) best = i;
    return best;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_prev = '0; m_pend = '0; m_isv = '0;
    end else begin
      int sel;
      int top;
      sel = m_pick(m_pend, m_isv);
      if (irq_ret && m_isv != 0) begin
        top = m_level(m_isv);
        m_isv[top] = 1'b0;
      end
      if (irq_ack && sel >= 0) begin
        m_isv[sel] = 1'b1;
        m_pend[sel] = 1'b0;
      end
      for (int i = 0; i < N; i++)
        if (irq_req[i] && !m_prev[i]) m_pend[i] = 1'b1;
      m_prev = irq_req;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      int sel;
      sel = m_pick(m_pend, m_isv);
      checks++;
      if (irq_valid !== (sel >= 0) || (sel >= 0 && int'(irq_id) != sel)) begin
        errors++;
        $display("FAIL %s model: valid=%0b id=%0d expected valid=%0b id=%0d",
                 cur_tag, irq_valid, irq_id, sel >= 0, sel);
      end
    end
  end

  task automatic expect_out(input bit ev, input int eid, input string tag);
    checks++;
    if (irq_valid !== ev || (ev && int'(irq_id) != eid)) begin
      errors++;
      $display("FAIL %s: valid=%0b id=%0d expected valid=%0b id=%0d",
               tag, irq_valid, irq_id, ev, eid);
    end
  endtask

  task automatic step(input bit a, input bit r);
    irq_ack = a;
    irq_ret = r;
    @(negedge clk);
    irq_ack = 1'b0;
    irq_ret = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    expect_out(0, 0, "R1");
    step(0, 0);
    expect_out(0, 0, "R1");

    cur_tag = "R2";
    irq_req = 8'h04; step(0, 0);
    expect_out(1, 2, "R2 R4");
    step(1, 0);
    expect_out(0, 0, "R7");
    step(0, 0);
    expect_out(0, 0, "R2 held");

    cur_tag = "R5";
    irq_req = 8'h06; step(0, 0);
    expect_out(0, 0, "R5 lower");
    irq_req = 8'h02; step(0, 0);
    irq_req = 8'h06; step(0, 0);
    expect_out(0, 0, "R5 equal");

    cur_tag = "R6";
    irq_req = 8'h26; step(0, 0);
    expect_out(1, 5, "R6");
    cur_tag = "R11";
    irq_req = 8'hA6; step(0, 0);
    expect_out(1, 7, "R11 upward");
    step(0, 0);
    expect_out(1, 7, "R11 hold");
    step(1, 0);
    expect_out(0, 0, "R5 above 7");

    cur_tag = "R8";
    step(0, 1);
    expect_out(1, 5, "R8");
    irq_req = 8'hB6; step(0, 0);
    expect_out(1, 5, "R11 lower arrival");

    cur_tag = "R10";
    step(1, 1);
    expect_out(0, 0, "R10");
    step(0, 1);
    expect_out(1, 4, "R8 restore");
    step(1, 0);
    step(0, 1);
    expect_out(1, 2, "R8");
    step(1, 0);
    expect_out(0, 0, "R5");
    step(0, 1);
    expect_out(1, 1, "R8");
    step(1, 0);
    step(0, 1);
    expect_out(0, 0, "R8 drained");

    cur_tag = "R9";
    irq_req = '0; step(0, 0);
    step(1, 0);
    step(0, 1);
    expect_out(0, 0, "R9");
    irq_req = 8'h01; step(0, 0);
    expect_out(1, 0, "R7 idle ack R9");
    step(1, 0);
    irq_req = 8'h09; step(0, 0);
    expect_out(1, 3, "R6 nest");
    step(1, 0);
    step(0, 1);
    step(0, 1);
    expect_out(0, 0, "R8");

    cur_tag = "R3";
    irq_req = '0; step(0, 0);
    irq_req = 8'h0A; step(0, 0);
    expect_out(1, 3, "R3");
    step(1, 0);
    step(0, 1);
    expect_out(1, 1, "R3");
    step(1, 0);
    step(0, 1);
    expect_out(0, 0, "R4");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule